// File: doc/BRIEF.md
# Dead-Time-Free Pixel Hit Counter

A per-pixel counting stage for a binary photon-counting imager. Each discriminator pulse is recorded as one hit; no amplitude is kept. The pixel holds two equal counters that trade roles at every time-slice boundary. While one counter accumulates hits in the current slice, the other keeps the total from the slice that just ended, so it can be read out. No hit is lost while that value is being read.

The time slice is set from outside by a one-cycle toggle strobe, and no trigger is involved. At a toggle edge the counter that was accumulating freezes and becomes the readout value. The other counter is cleared and takes over the counting. A hit that arrives in the same cycle as the toggle belongs to the new slice. A non-zero flag tells the column sparsification logic whether this pixel has anything to report. A read enable gates the count onto the shared output.

Top module: `pixcnt_top`

## Requirements
- R1: After reset both counters are zero and the first slice counts in counter 0. `countOut` is 0 and `nonZero` is 0.
- R2: On each rising clock edge where `hitIn` is 1 and `sliceToggle` is 0, the counting counter increases by exactly one.
- R3: A counter that has reached 2^CNT_W-1 stays there on further hits and never wraps to zero.
- R4: On a rising edge with `sliceToggle` at 1, the counting counter's value becomes the readout value. This value is visible from the following cycle onward.
- R5: A hit sampled on the toggle edge is counted in the new slice, so the new counting counter starts at 1. Without such a hit it starts at 0.
- R6: The readout value does not change between toggles, whatever hits arrive.
- R7: `nonZero` is 1 exactly when the readout value is greater than zero, whatever the level of `readEn`.
- R8: `countOut` equals the readout value while `readEn` is 1 and is 0 while `readEn` is 0.
- R9: `readEn` has no effect on counting. After any pattern of `readEn`, the next readout value equals the number of hits in that slice, up to saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hitIn | input | 1 | One-cycle discriminator hit pulse, one hit per cycle high |
| sliceToggle | input | 1 | One-cycle time-slice boundary strobe |
| readEn | input | 1 | Gates the readout value onto countOut |
| countOut | output | CNT_W | Readout count of the previous slice, or 0 when not enabled |
| nonZero | output | 1 | Readout count is greater than zero |

## Verification
The bench builds the block with CNT_W = 3. This puts the saturation point at 7, so slices of about ten hits drive a counter into saturation and hold it there. It also keeps the normal counting patterns well below the ceiling. A cycle-accurate model in the bench follows both the live count and the readout count. The stimulus covers the toggle-coincident hit, back-to-back toggles and read-enable gating.

// File: rtl/pixcnt_pkg.sv
package pixcnt_pkg;
  // Strobes from the control half to the counter datapath
  typedef struct packed {
    logic [1:0] clr;    // load counter with 0 (or 1 if inc also set)
    logic [1:0] inc;    // count one hit
    logic       rdSel;  // index of the counter presented for readout
  } cntStrobes_t;
endpackage

// File: rtl/pixcnt_ctrl.sv
module pixcnt_ctrl
  import pixcnt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hitIn,
  input  logic        sliceToggle,
  output cntStrobes_t strb
);
  logic liveSel;  // index of the counter accumulating hits

  always_ff @(posedge clk) begin
    if (!rstN) liveSel <= 1'b0;
    else if (sliceToggle) liveSel <= ~liveSel;
  end

  always_comb begin
    strb = '0;
    strb.rdSel = ~liveSel;
    for (int k = 0; k < 2; k++) begin
      // new live counter on a toggle is the one not counting now
      strb.clr[k] = sliceToggle && (1'(k) != liveSel);
      strb.inc[k] = hitIn && (sliceToggle ? (1'(k) != liveSel) : (1'(k) == liveSel));
    end
  end

  // R2 R5: at most one counter counts a given hit
  a_r2_single_inc: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strb.inc) <= 1);
  // R4: roles swap on every toggle
  a_r4_role_swap: assert property (@(posedge clk) disable iff (!rstN)
    sliceToggle |=> strb.rdSel != $past(strb.rdSel));
endmodule

// File: rtl/pixcnt_dp.sv
module pixcnt_dp
  import pixcnt_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobes_t      strb,
  input  logic             readEn,
  output logic [CNT_W-1:0] countOut,
  output logic             nonZero,
  output logic [CNT_W-1:0] liveCount
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt [2];
  logic [CNT_W-1:0] rdVal;

  for (genvar i = 0; i < 2; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rstN)
        cnt[i] <= '0;
      else if (strb.clr[i])
        cnt[i] <= strb.inc[i] ? CNT_W'(1) : '0;
      else if (strb.inc[i] && cnt[i] != CntMax)
        cnt[i] <= cnt[i] + CNT_W'(1);
    end

    // R3: saturated counter holds
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
      (cnt[i] == CntMax && !strb.clr[i]) |=> cnt[i] == CntMax);
    // R6: idle counter keeps its value
    a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.clr[i] && !strb.inc[i]) |=> $stable(cnt[i]));
  end

  assign rdVal     = strb.rdSel ? cnt[1] : cnt[0];
  assign liveCount = strb.rdSel ? cnt[0] : cnt[1];
  assign nonZero   = rdVal != '0;
  assign countOut  = readEn ? rdVal : '0;
endmodule

// File: rtl/pixcnt_top.sv
module pixcnt_top
  import pixcnt_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hitIn,
  input  logic             sliceToggle,
  input  logic             readEn,
  output logic [CNT_W-1:0] countOut,
  output logic             nonZero
);
  cntStrobes_t      strb;
  logic [CNT_W-1:0] liveCount;

  pixcnt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hitIn(hitIn), .sliceToggle(sliceToggle), .strb(strb)
  );

  pixcnt_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .readEn(readEn),
    .countOut(countOut), .nonZero(nonZero), .liveCount(liveCount)
  );

  // R4 R7: flag after a toggle reflects the count that was live before it
  a_r4_handover: assert property (@(posedge clk) disable iff (!rstN)
    sliceToggle |=> nonZero == ($past(liveCount) != '0));
  // R8: output gated when not enabled
  a_r8_gate: assert property (@(posedge clk) disable iff (!rstN)
    !readEn |-> countOut == '0);
endmodule

// File: tb/pixcnt_tb.sv
module pixcnt_top_tb_top;
  localparam int W = 3;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hitIn = 1'b0;
  logic sliceToggle = 1'b0;
  logic readEn = 1'b0;
  logic [W-1:0] countOut;
  logic nonZero;

  int nChecks = 0;
  int nFails = 0;
  int liveM = 0;
  int rdM = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pixcnt_top #(.CNT_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .hitIn(hitIn), .sliceToggle(sliceToggle),
    .readEn(readEn), .countOut(countOut), .nonZero(nonZero)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one cycle: drive, clock edge, update model, sample 5 ns after the edge
  task automatic step(input bit h, input bit t, input bit r, input string req);
    hitIn = h; sliceToggle = t; readEn = r;
    @(posedge clk);
    if (t) begin
      rdM = liveM;            // R4 handover
      liveM = h ? 1 : 0;      // R5 coincident hit in new slice
    end else if (h && liveM < MAXV) begin
      liveM++;                // R2 count, R3 saturation
    end
    #5;
    check(req, int'(countOut), r ? rdM : 0, "countOut");  // R8
    check(req, int'(nonZero), (rdM != 0) ? 1 : 0, "nonZero");  // R7
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    rstN = 1'b1;
    readEn = 1'b1;
    #1;
    // R1 reset state
    check("R1", int'(countOut), 0, "countOut after reset");
    check("R1", int'(nonZero), 0, "nonZero after reset");

    // R2 R4: five hits then toggle, read five
    for (int i = 0; i < 5; i++) step(1, 0, 1, "R2");
    step(0, 1, 1, "R4");
    step(0, 0, 1, "R4");
    // R6: hits during readout keep readout stable
    for (int i = 0; i < 3; i++) step(1, 0, 1, "R6");
    // R5: hit coinciding with toggle
    step(1, 1, 1, "R5");
    step(0, 1, 1, "R5");  // new slice held just the coincident hit
    // R3: saturation in a long slice
    for (int i = 0; i < 12; i++) step(1, 0, 1, "R3");
    step(0, 1, 1, "R3");
    // back-to-back toggles, empty slices
    step(0, 1, 1, "R4");
    step(0, 1, 1, "R7");
    // R8 R9 R7: readEn toggling while counting
    for (int i = 0; i < 6; i++) step(1, 0, (i % 2) == 0, "R9");
    step(0, 1, 0, "R8");
    step(0, 0, 0, "R7");
    step(0, 0, 1, "R9");
    // mixed pattern
    for (int i = 0; i < 200; i++)
      step(((i * 7) % 3) != 0, (i % 13) == 12, (i % 5) != 1, "R2");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule